// File: doc/BRIEF.md
# Octal PSRAM Mode-Register Responder

This block is the target side of a byte-level octal pseudo-SRAM command link. It follows one transaction at a time, framed by an active-low chip select. For every byte the host delivers with its valid strobe, it returns a response byte in the same cycle. It builds a 16-bit command from the first two bytes and then lets a fixed number of dummy bytes pass. It takes a register address from the byte after the dummies, then either streams register contents back or stores one byte into a mode register.

The register bank holds six 8-bit mode registers with fixed power-up values. In this description they are called bank slots 0, 1, 2, 3, 4 and 8 after the address that selects them. Slots 0, 4 and 8 can be written. The others report fixed identity and configuration codes. A host uses the block to read out these codes and to change the latency, drive and burst settings.

Top module: `opsram_mreg_resp`

## Requirements
- R1: The byte at index 0 of a transaction is the low half of the command and the byte at index 1 is the high half. The value 0x4040 selects register read and 0xC0C0 selects register write. The reversed pair 0xC040 and every other value select neither.
- R2: The register address is taken from the byte at index DUMMY+2, which is index 5 with the default DUMMY of 3.
- R3: During any command, the response is 0x00 for every byte at indices 0 to 5.
- R4: During a register read, a byte at index i ≥ 6 brings the running count to i+1. When that count is even, the response is the addressed slot. When it is odd, the response is the slot that follows it. The pairs are 0→(0,1), 1→(1,2), 2→(2,3), 3→(3,4), 4→(4,8) and 8→(8,0).
- R5: A register read with an address outside {0,1,2,3,4,8} returns 0x00 on every byte.
- R6: During a register write, the byte at index 6 is stored into slot 0, 4 or 8 when the captured address is one of those. For any other address, the write leaves every slot unchanged. Every response byte of a write is 0x00.
- R7: Reset (rst_n low at a clock edge) sets slot 0 to 0x09, slot 1 to 0x0D, slot 2 to 0x93, slot 3 to 0x20, slot 4 to 0x20 and slot 8 to 0x05.
- R8: While cs_n is high, incoming bytes are ignored and the response is 0x00. Raising cs_n resets the byte position, command and address, so the next low period starts again at index 0.
- R9: The byte position saturates at 2^CNT_W−1 instead of wrapping. Even/odd alternation of read responses continues past saturation, and a long transfer never re-enters the command or address phases.
- R10: A transaction whose command is neither register read nor register write returns 0x00 on every byte and changes no slot.
- R11: The response for a byte is valid in the same cycle as its strobe, before the clock edge that accepts that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select framing a transaction |
| rx_valid | input | 1 | Strobe: rx_byte holds a received byte this cycle |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Response byte for the current received byte (combinational) |

## Verification
Two functions can meet in one cycle. The first is the write commit, or the saturation of the byte position, on the byte being accepted. The second is the same-cycle response that depends on the updated position. Each response is sampled mid-cycle, before the accepting edge, and compared with a value the bench works out from the byte index and a shadow copy of the slots. Chip select is also raised in the cycle right after a byte. The bench then holds rx_valid high with cs_n high, checks for a zero response, and confirms that the next transaction starts cleanly at index 0.

// File: rtl/opsram_mreg_resp.sv
module opsram_mreg_resp #(
  parameter int          DUMMY  = 3,
  parameter int          CNT_W  = 4,
  parameter logic [15:0] RD_CMD = 16'h4040,
  parameter logic [15:0] WR_CMD = 16'hC0C0,
  parameter logic [7:0]  DEF0   = 8'h09,
  parameter logic [7:0]  DEF1   = 8'h0D,
  parameter logic [7:0]  DEF2   = 8'h93,
  parameter logic [7:0]  DEF3   = 8'h20,
  parameter logic [7:0]  DEF4   = 8'h20,
  parameter logic [7:0]  DEF8   = 8'h05
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic [7:0] tx_byte
);
  localparam int ADDR_IDX = DUMMY + 2;
  localparam int DATA_CNT = ADDR_IDX + 2;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] ADDR_POS = CNT_W'(ADDR_IDX);
  localparam logic [CNT_W-1:0] DATA_POS = CNT_W'(DATA_CNT);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(DATA_CNT - 1);

  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             par, par_nx;
  logic [15:0]      cmd, cmd_nx;
  logic             cmd_v, cmd_v_nx;
  logic [7:0]       addr, addr_nx;
  logic             addr_v, addr_v_nx;
  logic [7:0]       mr0, mr1, mr2, mr3, mr4, mr8;
  logic [7:0]       rd_lo, rd_hi;

  wire take  = rx_valid & ~cs_n;
  wire is_rd = cmd_v_nx && (cmd_nx == RD_CMD);
  wire is_wr = cmd_v_nx && (cmd_nx == WR_CMD);
  wire wr_go = take && is_wr && addr_v && (cnt == LAST_POS);

  always_comb begin
    cnt_nx    = cnt;
    par_nx    = par;
    cmd_nx    = cmd;
    cmd_v_nx  = cmd_v;
    addr_nx   = addr;
    addr_v_nx = addr_v;
    if (take) begin
      if (cnt == '0) cmd_nx[7:0] = rx_byte;
      if (cnt == CNT_W'(1)) begin
        cmd_nx[15:8] = rx_byte;
        cmd_v_nx     = 1'b1;
      end
      if (cnt == ADDR_POS) begin
        addr_nx   = rx_byte;
        addr_v_nx = 1'b1;
      end
      if (cnt != CNT_MAX) cnt_nx = cnt + CNT_W'(1);
      par_nx = ~par;
    end
  end

  always_comb begin
    rd_lo = 8'h00;
    rd_hi = 8'h00;
    case (addr_nx)
      8'd0: begin rd_lo = mr0; rd_hi = mr1; end
      8'd1: begin rd_lo = mr1; rd_hi = mr2; end
      8'd2: begin rd_lo = mr2; rd_hi = mr3; end
      8'd3: begin rd_lo = mr3; rd_hi = mr4; end
      8'd4: begin rd_lo = mr4; rd_hi = mr8; end
      8'd8: begin rd_lo = mr8; rd_hi = mr0; end
      default: ;
    endcase
  end

  assign tx_byte = (take && is_rd && addr_v_nx && (cnt_nx >= DATA_POS))
                   ? (par_nx ? rd_hi : rd_lo) : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      par    <= 1'b0;
      cmd    <= 16'h0000;
      cmd_v  <= 1'b0;
      addr   <= 8'h00;
      addr_v <= 1'b0;
      mr0    <= DEF0;
      mr1    <= DEF1;
      mr2    <= DEF2;
      mr3    <= DEF3;
      mr4    <= DEF4;
      mr8    <= DEF8;
    end else if (cs_n) begin
      cnt    <= '0;
      par    <= 1'b0;
      cmd_v  <= 1'b0;
      addr_v <= 1'b0;
    end else begin
      cnt    <= cnt_nx;
      par    <= par_nx;
      cmd    <= cmd_nx;
      cmd_v  <= cmd_v_nx;
      addr   <= addr_nx;
      addr_v <= addr_v_nx;
      if (wr_go) begin
        case (addr)
          8'd0: mr0 <= rx_byte;
          8'd4: mr4 <= rx_byte;
          8'd8: mr8 <= rx_byte;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/opsram_mreg_resp_chk.sv
module opsram_mreg_resp_chk #(
  parameter int DUMMY = 3,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             rx_valid,
  input logic [7:0]       tx_byte,
  input logic [CNT_W-1:0] cnt,
  input logic             cmd_v,
  input logic             addr_v,
  input logic [7:0]       mr0,
  input logic [7:0]       mr1,
  input logic [7:0]       mr2,
  input logic [7:0]       mr3,
  input logic [7:0]       mr4,
  input logic [7:0]       mr8
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(DUMMY + 3);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !rx_valid) |-> tx_byte == 8'h00); // R8

  AST_CS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cnt == '0) && !cmd_v && !addr_v); // R8

  AST_EARLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && rx_valid && cnt < LAST_POS) |-> tx_byte == 8'h00); // R3

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cnt == CNT_MAX) |=> cnt == CNT_MAX); // R9

  AST_RO_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mr1) && $stable(mr2) && $stable(mr3)); // R6

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !rx_valid) |=> $stable(mr0) && $stable(mr4) && $stable(mr8)); // R8
endmodule

bind opsram_mreg_resp opsram_mreg_resp_chk #(.DUMMY(DUMMY), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .tx_byte(tx_byte),
  .cnt(cnt), .cmd_v(cmd_v), .addr_v(addr_v),
  .mr0(mr0), .mr1(mr1), .mr2(mr2), .mr3(mr3), .mr4(mr4), .mr8(mr8));

// File: tb/opsram_mreg_resp_test.sv
module opsram_mreg_resp_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [7:0] tx_byte;

  int tests = 0;
  int fails = 0;
  logic [7:0] shadow [0:15];

  opsram_mreg_resp uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
                        .rx_byte(rx_byte), .tx_byte(tx_byte));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic load_defaults();
    for (int i = 0; i < 16; i++) shadow[i] = 8'h00;
    shadow[0] = 8'h09; shadow[1] = 8'h0D; shadow[2] = 8'h93;
    shadow[3] = 8'h20; shadow[4] = 8'h20; shadow[8] = 8'h05;
  endtask

  function automatic int next_slot(input int a);
    case (a)
      0: return 1; 1: return 2; 2: return 3; 3: return 4; 4: return 8; 8: return 0;
      default: return -1;
    endcase
  endfunction

  task automatic send(input logic [7:0] b, output logic [7:0] r);
    @(negedge clk);
    cs_n = 1'b0; rx_valid = 1'b1; rx_byte = b;
    #5 r = tx_byte;
  endtask

  task automatic close_cs();
    @(negedge clk);
    rx_valid = 1'b0; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cs_n = 1'b1; rx_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    load_defaults();
  endtask

  // register read of nbytes, each response checked against the shadow
  task automatic read_txn(input int a, input int nbytes);
    logic [7:0] r, e;
    for (int i = 0; i < nbytes; i++) begin
      case (i)
        0, 1: send(8'h40, r);
        5: send(8'(a), r);
        default: send(8'h5A, r);
      endcase
      if (i < 6) e = 8'h00;
      else if (next_slot(a) < 0) e = 8'h00;
      else if (((i + 1) % 2) == 1) e = shadow[next_slot(a)];
      else e = shadow[a];
      if (i < 6) chk("R3 early bytes zero", r, e);
      else if (i >= 15) chk("R9 alternation past saturation", r, e);
      else if (next_slot(a) < 0) chk("R5 unmapped address", r, e);
      else if (i == 6) chk("R11 same-cycle response / R4 odd slot", r, e);
      else chk("R4 read pair", r, e);
    end
    close_cs();
  endtask

  task automatic write_txn(input logic [15:0] cmd, input int a, input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 7; i++) begin
      case (i)
        0: send(cmd[7:0], r);
        1: send(cmd[15:8], r);
        5: send(8'(a), r);
        6: send(v, r);
        default: send(8'h00, r);
      endcase
      if (cmd == 16'hC0C0) chk("R6 write response zero", r, 8'h00);
      else chk("R10 unknown command zero", r, 8'h00);
    end
    close_cs();
    if (cmd == 16'hC0C0 && (a == 0 || a == 4 || a == 8)) shadow[a] = v;
  endtask

  task automatic read_all(input int nbytes);
    for (int a = 0; a < 16; a++) read_txn(a, nbytes);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    do_reset();
    // R7 reset defaults, plus long reads crossing saturation (R9)
    read_all(20);

    // R6 writes to every address; only slots 0,4,8 change
    for (int a = 0; a < 16; a++) write_txn(16'hC0C0, a, 8'hA0 + 8'(a));
    read_all(9);

    // R1/R10 reversed and foreign commands change nothing
    write_txn(16'h40C0, 0, 8'h11);
    write_txn(16'hC040, 4, 8'h22);
    write_txn(16'h4041, 8, 8'h33);
    read_all(8);

    // R8 abort after command bytes, then bytes with cs_n high are ignored
    send(8'hC0, r); chk("R1 command byte zero", r, 8'h00);
    send(8'hC0, r); chk("R1 command byte zero", r, 8'h00);
    @(negedge clk); cs_n = 1'b1; rx_valid = 1'b1; rx_byte = 8'h00;
    #5 chk("R8 ignored byte zero", tx_byte, 8'h00);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); rx_byte = 8'(i);
      #5 chk("R8 ignored byte zero", tx_byte, 8'h00);
    end
    @(negedge clk); rx_valid = 1'b0;
    read_txn(0, 8);
    read_txn(4, 8);
    read_txn(8, 8);

    // R2 address byte position: write to slot 8 after a dummy resembling slot 0
    write_txn(16'hC0C0, 8, 8'h7E);
    read_txn(8, 8);

    // R7 reset restores defaults after writes
    do_reset();
    read_all(8);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule